// File: doc/BRIEF.md
# Two-Line Interrupt Aggregator

This block gathers up to 32 single-cycle event pulses from a bus controller into a sticky status register. Each status bit is then filtered by its own enable bit and steered, through a per-bit routing register, to one of two interrupt outputs. Each output also has a master gate bit of its own. Software reads the pending set, handles it, and writes the same value back to clear exactly what it has seen.

Four 32-bit registers are reached through a simple single-cycle write strobe and a combinational read mux: pending status (write-one-to-clear), per-bit enable, per-bit output routing and the two output gates. The meaning of each event is not known to the block. Only the bit position matters. For example, bit 0 is the receive-queue new-entry event, bit 3 is receive-queue loss, bits 23 to 25 are error-state changes and bits 27 to 31 are protocol errors.

Top module: `evt_irq_aggregator`

## Requirements
- R1: After reset all four registers read 0 and both interrupt outputs are 0.
- R2: A 1 on evt_i[n] during a clock edge sets status bit n. The bit then stays set until software clears it.
- R3: A write to address 0 clears each status bit whose write-data bit is 1. A status bit whose write-data bit is 0 is left unchanged.
- R4: If an event on bit n arrives in the same cycle as a write that clears bit n, bit n ends up set.
- R5: A pending status bit has no effect on either output while its enable bit (address 1) is 0. As an example, enable 0x07FFFFFF masks only the protocol-error bits 27 to 31.
- R6: A pending and enabled bit n drives line 0 when routing bit n (address 2) is 0, and drives line 1 when it is 1.
- R7: Line-gate bit 0 (address 3) gates irq_o[0], and bit 1 gates irq_o[1]. Clearing a gate does not change the status register. Setting the gate again makes the line assert again if its bits are still pending.
- R8: The outputs are registered and active-high. They reflect the register state one clock edge after the edge that updated it.
- R9: Addresses 0 to 3 read back status, enable, routing and gate. The gate register stores only bits 1:0, and its upper read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 32 | Event pulses, one per status bit |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 status, 1 enable, 2 routing, 3 gate) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 2 | Interrupt lines, bit 0 is line 0 |

## Verification
The hardest case to create from the ports is a collision: an event pulse and a clearing write to the same status bit landing on the same clock edge. The bench reaches this case by driving both evt_i and the write strobe on the same falling edge. It then reads the status back after that edge. The second hard case is a line gate switched off while bits are still pending. The bench checks that the status readback is unchanged, and that the line returns one edge after the gate is set again, with no new event.

// File: rtl/irqagg_pkg.sv
// Shared definitions for the interrupt aggregator.
// Assumes a 2-bit register address space with four word registers.
package irqagg_pkg;
    localparam int REG_W     = 32;
    localparam int NUM_LINES = 2;

    typedef enum logic [1:0] {
        ADDR_STATUS = 2'd0,
        ADDR_ENABLE = 2'd1,
        ADDR_ROUTE  = 2'd2,
        ADDR_GATE   = 2'd3
    } irqagg_addr_e;
endpackage

// File: rtl/irqagg_status.sv
// Sticky pending register: events set bits, write-one-to-clear removes them.
// Assumes events are sampled on every edge. A set in the same cycle as a clear wins.
module irqagg_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);
    logic [W-1:0] clr_eff;

    // Purpose: qualify the clear mask with the write strobe.
    always_comb begin
        clr_eff = clr_wr ? clr_mask : '0;
    end

    // Purpose: hold pending bits; the new event takes priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_eff) | evt;
    end
endmodule

// File: rtl/irqagg_cfg.sv
// Configuration registers: per-bit enable, per-bit line routing, line gates.
// Assumes one write per cycle, decoded from the shared address.
module irqagg_cfg #(
    parameter int W     = 32,
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     enable,
    output logic [W-1:0]     route,
    output logic [LINES-1:0] gate
);
    import irqagg_pkg::*;

    // Purpose: per-bit enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)                        enable <= '0;
        else if (wr && addr == ADDR_ENABLE) enable <= wdata;
    end

    // Purpose: per-bit line routing, 0 selects line 0 and 1 selects line 1.
    always_ff @(posedge clk) begin
        if (!rst_n)                       route <= '0;
        else if (wr && addr == ADDR_ROUTE) route <= wdata;
    end

    // Purpose: master gate per output line, only the low bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)                      gate <= '0;
        else if (wr && addr == ADDR_GATE) gate <= wdata[LINES-1:0];
    end
endmodule

// File: rtl/irqagg_route.sv
// Output stage: reduces the enabled pending bits of each line and registers the result.
// Assumes exactly two lines, selected by one routing bit per status bit.
module irqagg_route #(
    parameter int W     = 32,
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     status,
    input  logic [W-1:0]     enable,
    input  logic [W-1:0]     route,
    input  logic [LINES-1:0] gate,
    output logic [LINES-1:0] irq
);
    logic [W-1:0] active;

    // Purpose: pending bits that software has enabled.
    always_comb begin
        active = status & enable;
    end

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [W-1:0] sel_mask;
        logic         hit;

        // Purpose: pick the bits steered to this line and reduce them.
        always_comb begin
            sel_mask = (l == 0) ? ~route : route;
            hit      = gate[l] && (|(active & sel_mask));
        end

        // Purpose: registered level output for this line.
        always_ff @(posedge clk) begin
            if (!rst_n) irq[l] <= 1'b0;
            else        irq[l] <= hit;
        end
    end
endmodule

// File: rtl/evt_irq_aggregator.sv
// Top of the two-line interrupt aggregator: status, configuration, routing and readback.
// Assumes single-cycle write strobes. Reads are combinational from reg_addr_i.
module evt_irq_aggregator #(
    parameter int W     = irqagg_pkg::REG_W,
    parameter int LINES = irqagg_pkg::NUM_LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     evt_i,
    input  logic             reg_wr_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [W-1:0]     reg_wdata_i,
    output logic [W-1:0]     reg_rdata_o,
    output logic [LINES-1:0] irq_o
);
    import irqagg_pkg::*;

    logic [W-1:0]     status_q;
    logic [W-1:0]     enable_q;
    logic [W-1:0]     route_q;
    logic [LINES-1:0] gate_q;
    logic             clr_wr;

    // Purpose: decode a write to the status word as a clear request.
    always_comb begin
        clr_wr = reg_wr_i && (reg_addr_i == ADDR_STATUS);
    end

    irqagg_status #(.W(W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_i),
        .clr_wr   (clr_wr),
        .clr_mask (reg_wdata_i),
        .status   (status_q)
    );

    irqagg_cfg #(.W(W), .LINES(LINES)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr_i),
        .addr   (reg_addr_i),
        .wdata  (reg_wdata_i),
        .enable (enable_q),
        .route  (route_q),
        .gate   (gate_q)
    );

    irqagg_route #(.W(W), .LINES(LINES)) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status_q),
        .enable (enable_q),
        .route  (route_q),
        .gate   (gate_q),
        .irq    (irq_o)
    );

    // Purpose: readback mux; the gate word is zero-extended.
    always_comb begin
        unique case (reg_addr_i)
            ADDR_STATUS: reg_rdata_o = status_q;
            ADDR_ENABLE: reg_rdata_o = enable_q;
            ADDR_ROUTE:  reg_rdata_o = route_q;
            default:     reg_rdata_o = {{(W-LINES){1'b0}}, gate_q};
        endcase
    end
endmodule

// File: rtl/irqagg_checker.sv
// Property checker for the aggregator, attached to the top with bind.
// Assumes exactly two lines, matching the routing convention.
module irqagg_checker #(
    parameter int W     = 32,
    parameter int LINES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [W-1:0]     evt,
    input logic             wr,
    input logic [1:0]       addr,
    input logic [W-1:0]     wdata,
    input logic [W-1:0]     status,
    input logic [W-1:0]     enable,
    input logic [W-1:0]     route,
    input logic [LINES-1:0] gate,
    input logic [LINES-1:0] irq
);
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == 2'd0) |=> ((status & $past(status)) == $past(status)));

    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd0 && evt == '0) |=> (status == ($past(status) & ~$past(wdata))));

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

    assert_line0_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |-> $past(|(status & enable & ~route)));

    assert_line1_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq[1] |-> $past(|(status & enable & route)));

    assert_gate0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |-> $past(gate[0]));

    assert_gate1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq[1] |-> $past(gate[1]));
endmodule

bind evt_irq_aggregator irqagg_checker #(.W(W), .LINES(LINES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt_i),
    .wr     (reg_wr_i),
    .addr   (reg_addr_i),
    .wdata  (reg_wdata_i),
    .status (status_q),
    .enable (enable_q),
    .route  (route_q),
    .gate   (gate_q),
    .irq    (irq_o)
);

// File: tb/sim_evt_irq_aggregator.sv
// Directed bench for the aggregator: one task per scenario, each checks its own results.
module sim_evt_irq_aggregator;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [1:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [1:0]  irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    evt_irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr_i(reg_wr_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Drive on a falling edge; the register updates on the next rising edge.
    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        tick();
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic pulse(input logic [31:0] e);
        evt_i = e;
        tick();
        evt_i = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 4; a++) begin
            rd_reg(a[1:0], d);
            check("R1 reset reg", d, 32'h0);
        end
        check("R1 reset irq", {30'b0, irq_o}, 32'h0);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        pulse(32'h0000_0008);
        tick(); tick();
        rd_reg(2'd0, d);
        check("R2 sticky bit3", d, 32'h0000_0008);
        check("R5 disabled no irq", {30'b0, irq_o}, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        pulse(32'h0000_0400);
        rd_reg(2'd0, d);
        check("R2 two pending", d, 32'h0000_0408);
        wr_reg(2'd0, 32'h0000_0400);
        rd_reg(2'd0, d);
        check("R3 clear bit10 only", d, 32'h0000_0008);
        wr_reg(2'd0, 32'h0000_0000);
        rd_reg(2'd0, d);
        check("R3 zero write keeps", d, 32'h0000_0008);
        wr_reg(2'd0, 32'h0000_0008);
        rd_reg(2'd0, d);
        check("R3 clear bit3", d, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        pulse(32'h0000_0001);
        evt_i = 32'h0000_0001;
        wr_reg(2'd0, 32'h0000_0003);
        evt_i = '0;
        rd_reg(2'd0, d);
        check("R4 set beats clear", d, 32'h0000_0001);
        wr_reg(2'd0, 32'hFFFF_FFFF);
        rd_reg(2'd0, d);
        check("R4 later clear", d, 32'h0);
    endtask

    task automatic t_route();
        wr_reg(2'd1, 32'hFFFF_FFFF);
        wr_reg(2'd2, 32'h0100_0000);
        wr_reg(2'd3, 32'h0000_0003);
        pulse(32'h0000_0004);
        check("R8 irq lags status", {30'b0, irq_o}, 32'h0);
        tick();
        check("R6 bit2 to line0", {30'b0, irq_o}, 32'h1);
        pulse(32'h0100_0000);
        tick();
        check("R6 bit24 to line1", {30'b0, irq_o}, 32'h3);
        wr_reg(2'd0, 32'h0000_0004);
        tick();
        check("R6 only line1 left", {30'b0, irq_o}, 32'h2);
        wr_reg(2'd0, 32'hFFFF_FFFF);
        tick();
        check("R6 all cleared", {30'b0, irq_o}, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr_reg(2'd2, 32'h0);
        wr_reg(2'd1, 32'h07FF_FFFF);
        pulse(32'h2000_0000);
        tick();
        rd_reg(2'd0, d);
        check("R5 bit29 pending", d, 32'h2000_0000);
        check("R5 bit29 masked", {30'b0, irq_o}, 32'h0);
        pulse(32'h0000_0001);
        tick();
        check("R5 bit0 enabled", {30'b0, irq_o}, 32'h1);
    endtask

    task automatic t_gate();
        logic [31:0] d;
        wr_reg(2'd3, 32'h0);
        tick();
        check("R7 gate off", {30'b0, irq_o}, 32'h0);
        rd_reg(2'd0, d);
        check("R7 status kept", d, 32'h2000_0001);
        wr_reg(2'd3, 32'h2);
        tick();
        check("R7 line0 still off", {30'b0, irq_o}, 32'h0);
        wr_reg(2'd3, 32'hFFFF_FFFF);
        tick();
        check("R7 line0 back", {30'b0, irq_o}, 32'h1);
        rd_reg(2'd3, d);
        check("R9 gate readback", d, 32'h3);
        rd_reg(2'd1, d);
        check("R9 enable readback", d, 32'h07FF_FFFF);
    endtask

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_sticky();
        t_w1c();
        t_set_wins();
        t_route();
        t_mask();
        t_gate();
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule